// File: doc/BRIEF.md
# Break-Before-Make Gate Sequencer

This block sits between a PWM comparator and the two gate drivers of a synchronous buck half-bridge. It takes one demand bit and turns it into separate enables for the high-side and low-side switches, and it never lets both be on at once. Each driver returns a digital flag that says its gate voltage has fallen below the turn-off threshold. The sequencer waits for the opposite gate's flag before it turns the next gate on. A fixed number of extra cycles is added only when the high side is about to turn on.

A fault sequencer can override the demand in two ways. It can hold both gates off, which leaves the switch node floating. It can also force the low side on with the high side off, to discharge an overvoltage or ride out an overcurrent. A watchdog on each wait guards against a driver whose feedback never reports the gate low. When it expires, both gates go off and a sticky error flag is raised. Only reset clears that flag.

Top module: `bbm_gate_sequencer`

## Requirements
- R1: `hs_en` and `ls_en` are never 1 in the same cycle.
- R2: `ls_en` rises only on the clock edge after a cycle in which `hs_gate_low` was sampled 1 and `hs_en` was 0. While the sequencer waits for that flag, both enables stay 0.
- R3: On a low-to-high handover, `hs_en` rises on the edge at which `ls_gate_low` has been sampled 1 in `DEAD_CYC` consecutive wait cycles. A 0 sample restarts the count. The count is a parameter only, with no run-time control.
- R4: With no override, a sampled demand of 0 clears `hs_en` at that edge. A sampled demand of 1 clears `ls_en` at that edge. The opposite gate then follows per R2 or R3.
- R5: A sampled `force_off` = 1 makes both enables 0 at that edge, and they stay 0 while it is held. After release, the block leaves the all-off state only at an edge where both feedback flags are 1. It then goes to the low side (demand 0) or starts the R3 dead-time count (demand 1).
- R6: A sampled `force_ls` = 1 (with `force_off` = 0) acts as a demand of 0 whatever `pwm_req` is. `hs_en` is 0 after that edge and the low side comes on per R2.
- R7: If the demand returns to its previous value while a wait is pending, the gate that was just switched off comes back on at the next edge. A low-side return also needs `hs_gate_low` = 1. The opposite gate is never energized.
- R8: If a wait lasts `TIMEOUT_CYC` sampled cycles without completing, both enables go to 0 and `stuck_err` goes to 1 at that edge. The error then holds both gates off until reset.
- R9: A synchronous reset (`rst_n` = 0) clears both enables and `stuck_err`. After reset, the block stays all-off until both feedback flags are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_req | input | 1 | PWM demand: 1 asks for high side, 0 for low side |
| hs_gate_low | input | 1 | High-side gate is below the turn-off threshold |
| ls_gate_low | input | 1 | Low-side gate is below the turn-off threshold |
| force_off | input | 1 | Fault override: both gates off |
| force_ls | input | 1 | Fault override: low side on, high side off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| stuck_err | output | 1 | Sticky flag: a gate feedback wait timed out |

## Verification
Some behaviours are checked on every cycle. These are: the enables are mutually exclusive, the low side rises only after the high-side flag was seen low, and a fresh high-side turn-on follows at least the dead-time window of low-side flag samples. The overrides take effect within one edge, and the error both persists and forces the gates off. Other behaviours need the bench's scenarios. These include the exact cycle of each handover, the dead-time count restarting on a feedback glitch, a demand reversal mid-wait returning to its original gate, and the all-off state waiting for both flags. The timeout firing on exactly the configured sample and reset clearing the error also come from the scenarios.

// File: rtl/bbm_pkg.sv
// Package: shared state encoding for the gate sequencer.
// Assumes: nothing outside this package depends on the numeric codes.
package bbm_pkg;

    typedef enum logic [2:0] {
        ST_ALL_OFF   = 3'd0,
        ST_HI_ON     = 3'd1,
        ST_HI_DRAIN  = 3'd2,
        ST_LO_ON     = 3'd3,
        ST_LO_DRAIN  = 3'd4
    } bbm_state_e;

endpackage

// File: rtl/bbm_step_counter.sv
// Module: synchronous up-counter with clear priority.
// Assumes: the parent keeps the count below 2**WIDTH by clearing it in time.
module bbm_step_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);

    // Purpose: hold count at zero on reset or clear, otherwise step on inc.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + WIDTH'(1);
        end
    end

endmodule

// File: rtl/bbm_transition.sv
// Module: next-state logic of the break-before-make sequencer.
// Assumes: dead_cnt counts consecutive low-side-low samples in ST_LO_DRAIN,
// and wait_cnt counts samples spent in the current drain state.
module bbm_transition
    import bbm_pkg::*;
#(
    parameter int DEAD_CYC    = 4,
    parameter int TIMEOUT_CYC = 64,
    parameter int DW          = 3,
    parameter int TW          = 7
) (
    input  bbm_state_e    state,
    input  logic          pwm_req,
    input  logic          force_off,
    input  logic          force_ls,
    input  logic          hs_gate_low,
    input  logic          ls_gate_low,
    input  logic          err_q,
    input  logic [DW-1:0] dead_cnt,
    input  logic [TW-1:0] wait_cnt,
    output bbm_state_e    state_nxt,
    output logic          err_set
);

    logic want_hi;
    logic dead_done;
    logic timed_out;

    // Purpose: qualify the demand and the two counter thresholds.
    always_comb begin
        want_hi   = pwm_req && !force_ls;
        dead_done = ls_gate_low && (dead_cnt == DW'(DEAD_CYC - 1));
        timed_out = (wait_cnt == TW'(TIMEOUT_CYC - 1));
    end

    // Purpose: pick the next state, overrides and errors first.
    always_comb begin
        state_nxt = state;
        err_set   = 1'b0;
        if (force_off || err_q) begin
            state_nxt = ST_ALL_OFF;
        end else begin
            unique case (state)
                ST_ALL_OFF: begin
                    if (hs_gate_low && ls_gate_low) begin
                        state_nxt = want_hi ? ST_LO_DRAIN : ST_LO_ON;
                    end
                end
                ST_HI_ON: begin
                    if (!want_hi) state_nxt = ST_HI_DRAIN;
                end
                ST_HI_DRAIN: begin
                    if (want_hi) begin
                        state_nxt = ST_HI_ON;
                    end else if (hs_gate_low) begin
                        state_nxt = ST_LO_ON;
                    end else if (timed_out) begin
                        state_nxt = ST_ALL_OFF;
                        err_set   = 1'b1;
                    end
                end
                ST_LO_ON: begin
                    if (want_hi) state_nxt = ST_LO_DRAIN;
                end
                ST_LO_DRAIN: begin
                    if (!want_hi && hs_gate_low) begin
                        state_nxt = ST_LO_ON;
                    end else if (want_hi && dead_done) begin
                        state_nxt = ST_HI_ON;
                    end else if (timed_out) begin
                        state_nxt = ST_ALL_OFF;
                        err_set   = 1'b1;
                    end
                end
                default: state_nxt = ST_ALL_OFF;
            endcase
        end
    end

endmodule

// File: rtl/bbm_gate_sequencer.sv
// Module: break-before-make sequencer for a synchronous half-bridge.
// Turns one PWM demand into two registered gate enables, waiting on the
// opposite gate's low feedback and, before high-side turn-on, on a fixed
// count of low-side-low samples. Overrides and a wait timeout force gates off.
// Assumes: feedback inputs are already synchronous to clk; DEAD_CYC >= 1 and
// TIMEOUT_CYC > DEAD_CYC.
module bbm_gate_sequencer
    import bbm_pkg::*;
#(
    parameter int DEAD_CYC    = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic hs_gate_low,
    input  logic ls_gate_low,
    input  logic force_off,
    input  logic force_ls,
    output logic hs_en,
    output logic ls_en,
    output logic stuck_err
);

    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    bbm_state_e    state_q;
    bbm_state_e    state_nxt;
    logic          err_set;
    logic [DW-1:0] dead_cnt;
    logic [TW-1:0] wait_cnt;
    logic          dead_clr;
    logic          wait_clr;

    // Purpose: restart the counters whenever their window is not running.
    always_comb begin
        dead_clr = (state_q != ST_LO_DRAIN) || !ls_gate_low;
        wait_clr = (state_q != ST_LO_DRAIN) && (state_q != ST_HI_DRAIN);
    end

    bbm_step_counter #(.WIDTH(DW)) u_dead_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dead_clr),
        .inc   (1'b1),
        .count (dead_cnt)
    );

    bbm_step_counter #(.WIDTH(TW)) u_wait_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wait_clr),
        .inc   (1'b1),
        .count (wait_cnt)
    );

    bbm_transition #(
        .DEAD_CYC    (DEAD_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .DW          (DW),
        .TW          (TW)
    ) u_transition (
        .state       (state_q),
        .pwm_req     (pwm_req),
        .force_off   (force_off),
        .force_ls    (force_ls),
        .hs_gate_low (hs_gate_low),
        .ls_gate_low (ls_gate_low),
        .err_q       (stuck_err),
        .dead_cnt    (dead_cnt),
        .wait_cnt    (wait_cnt),
        .state_nxt   (state_nxt),
        .err_set     (err_set)
    );

    // Purpose: register state, sticky error and glitch-free gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_ALL_OFF;
            stuck_err <= 1'b0;
            hs_en     <= 1'b0;
            ls_en     <= 1'b0;
        end else begin
            state_q   <= state_nxt;
            stuck_err <= stuck_err || err_set;
            hs_en     <= (state_nxt == ST_HI_ON);
            ls_en     <= (state_nxt == ST_LO_ON);
        end
    end

endmodule

// File: rtl/bbm_gate_sequencer_chk.sv
// Module: protocol checker for the gate sequencer, bound to every instance.
// Assumes: it sees only the ports of the sequencer; windows are counted here.
module bbm_gate_sequencer_chk #(
    parameter int DEAD_CYC    = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input logic clk,
    input logic rst_n,
    input logic hs_gate_low,
    input logic ls_gate_low,
    input logic force_off,
    input logic force_ls,
    input logic hs_en,
    input logic ls_en,
    input logic stuck_err
);

    localparam int RW = $clog2(DEAD_CYC + 1);
    localparam int OW = $clog2(TIMEOUT_CYC + 1);

    logic [RW-1:0] lo_run;
    logic [OW-1:0] off_run;

    // Purpose: count consecutive samples of a discharged, disabled low side.
    always_ff @(posedge clk) begin
        if (!rst_n || !ls_gate_low || ls_en) begin
            lo_run <= '0;
        end else if (lo_run != RW'(DEAD_CYC)) begin
            lo_run <= lo_run + RW'(1);
        end
    end

    // Purpose: count consecutive samples with both gates disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || hs_en || ls_en) begin
            off_run <= '0;
        end else if (off_run != OW'(TIMEOUT_CYC)) begin
            off_run <= off_run + OW'(1);
        end
    end

    p_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    p_lo_after_hi_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> ($past(hs_gate_low) && !$past(hs_en)));

    p_dead_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_en) && !$past(hs_en, 2)) |-> (lo_run >= RW'(DEAD_CYC)));

    p_force_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!hs_en && !ls_en));

    p_force_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ls && !force_off) |=> !hs_en);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_err |=> stuck_err);

    p_err_gates_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_err |-> (!hs_en && !ls_en));

    p_err_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck_err) |-> (off_run >= OW'(TIMEOUT_CYC)));

endmodule

bind bbm_gate_sequencer bbm_gate_sequencer_chk #(
    .DEAD_CYC    (DEAD_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_gate_low (hs_gate_low),
    .ls_gate_low (ls_gate_low),
    .force_off   (force_off),
    .force_ls    (force_ls),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .stuck_err   (stuck_err)
);

// File: tb/bbm_gate_sequencer_tb.sv
// Bench: scoreboard. The driver sets inputs at the falling edge and queues
// the outputs expected after the next rising edge; the monitor compares.
module bbm_gate_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEAD       = 3;
    localparam int TMO        = 10;

    typedef struct {
        logic  hs;
        logic  ls;
        logic  err;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0;
    logic hs_gate_low = 1'b0;
    logic ls_gate_low = 1'b0;
    logic force_off = 1'b0;
    logic force_ls = 1'b0;
    logic hs_en;
    logic ls_en;
    logic stuck_err;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bbm_gate_sequencer #(.DEAD_CYC(DEAD), .TIMEOUT_CYC(TMO)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_req     (pwm_req),
        .hs_gate_low (hs_gate_low),
        .ls_gate_low (ls_gate_low),
        .force_off   (force_off),
        .force_ls    (force_ls),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .stuck_err   (stuck_err)
    );

    // Driver: one clock of stimulus plus the outputs expected after it.
    task automatic cyc(input logic r, input logic p, input logic hl,
                       input logic ll, input logic fo, input logic fl,
                       input logic eh, input logic el, input logic ee,
                       input string tag);
        exp_t e;
        @(negedge clk);
        rst_n       = r;
        pwm_req     = p;
        hs_gate_low = hl;
        ls_gate_low = ll;
        force_off   = fo;
        force_ls    = fl;
        e.hs = eh; e.ls = el; e.err = ee; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: after each rising edge, pop and compare one expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (hs_en !== e.hs || ls_en !== e.ls || stuck_err !== e.err) begin
                    failures++;
                    $display("FAIL %s actual hs=%b ls=%b err=%b expected hs=%b ls=%b err=%b",
                             e.tag, hs_en, ls_en, stuck_err, e.hs, e.ls, e.err);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset state, then stay off until both flags are low
        cyc(0,0,0,0,0,0, 0,0,0, "R9 reset");
        cyc(0,0,0,0,0,0, 0,0,0, "R9 reset");
        cyc(1,0,0,1,0,0, 0,0,0, "R9 hs flag high keeps off");
        cyc(1,0,1,1,0,0, 0,1,0, "R9 exit to low side");
        // R4/R3: low to high handover with dead time
        cyc(1,1,1,1,0,0, 0,0,0, "R4 ls drops on demand");
        cyc(1,1,1,0,0,0, 0,0,0, "R3 ls flag not low");
        cyc(1,1,1,1,0,0, 0,0,0, "R3 dead 1");
        cyc(1,1,1,1,0,0, 0,0,0, "R3 dead 2");
        cyc(1,1,1,1,0,0, 1,0,0, "R3 hs on after dead");
        cyc(1,1,0,1,0,0, 1,0,0, "R4 hs holds");
        // R4/R2: high to low handover waits for hs flag
        cyc(1,0,0,1,0,0, 0,0,0, "R4 hs drops on demand");
        cyc(1,0,0,1,0,0, 0,0,0, "R2 wait hs flag");
        cyc(1,0,1,1,0,0, 0,1,0, "R2 ls on after hs low");
        // R3: glitch on ls flag restarts the count
        cyc(1,1,1,1,0,0, 0,0,0, "R3 enter wait");
        cyc(1,1,1,1,0,0, 0,0,0, "R3 count 1");
        cyc(1,1,1,1,0,0, 0,0,0, "R3 count 2");
        cyc(1,1,1,0,0,0, 0,0,0, "R3 glitch restarts");
        cyc(1,1,1,1,0,0, 0,0,0, "R3 recount 1");
        cyc(1,1,1,1,0,0, 0,0,0, "R3 recount 2");
        cyc(1,1,1,1,0,0, 1,0,0, "R3 hs on after restart");
        // R7: reversals during pending waits
        cyc(1,0,0,1,0,0, 0,0,0, "R7 hs drain");
        cyc(1,1,0,1,0,0, 1,0,0, "R7 back to hs");
        cyc(1,0,0,1,0,0, 0,0,0, "R7 hs drain again");
        cyc(1,0,1,1,0,0, 0,1,0, "R7 ls on");
        cyc(1,1,1,1,0,0, 0,0,0, "R7 ls drain");
        cyc(1,1,1,1,0,0, 0,0,0, "R7 ls drain count");
        cyc(1,0,1,1,0,0, 0,1,0, "R7 back to ls");
        // R6: forced low side
        cyc(1,1,1,1,0,1, 0,1,0, "R6 force keeps ls");
        cyc(1,1,1,1,0,0, 0,0,0, "R6 release demand hs");
        cyc(1,1,1,1,0,0, 0,0,0, "R6 dead 1");
        cyc(1,1,1,1,0,0, 0,0,0, "R6 dead 2");
        cyc(1,1,1,1,0,0, 1,0,0, "R6 hs on");
        cyc(1,1,0,1,0,1, 0,0,0, "R6 force drops hs");
        cyc(1,1,1,1,0,1, 0,1,0, "R6 force ls on");
        cyc(1,1,1,1,0,1, 0,1,0, "R6 force holds ls");
        cyc(1,0,1,1,0,0, 0,1,0, "R6 release demand ls");
        // R5: forced all-off and exit conditions
        cyc(1,0,1,1,1,0, 0,0,0, "R5 force off");
        cyc(1,1,1,1,1,0, 0,0,0, "R5 held off");
        cyc(1,1,1,0,0,0, 0,0,0, "R5 waits ls flag");
        cyc(1,1,1,1,0,0, 0,0,0, "R5 exit into dead wait");
        cyc(1,1,1,1,0,0, 0,0,0, "R5 dead 1");
        cyc(1,1,1,1,0,0, 0,0,0, "R5 dead 2");
        cyc(1,1,1,1,0,0, 1,0,0, "R5 hs on after dead");
        cyc(1,1,0,1,1,0, 0,0,0, "R5 force off from hs");
        cyc(1,0,1,1,0,0, 0,1,0, "R5 exit to ls");
        // R8: stuck ls feedback times out
        cyc(1,1,1,0,0,0, 0,0,0, "R8 enter wait");
        for (int i = 1; i < TMO; i++) begin
            cyc(1,1,1,0,0,0, 0,0,0, "R8 before timeout");
        end
        cyc(1,1,1,0,0,0, 0,0,1, "R8 timeout");
        cyc(1,0,1,1,0,0, 0,0,1, "R8 error sticky");
        cyc(1,0,1,1,0,0, 0,0,1, "R8 error sticky");
        cyc(0,0,1,1,0,0, 0,0,0, "R9 reset clears error");
        cyc(1,0,1,1,0,0, 0,1,0, "R9 resume ls");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule